// File: doc/BRIEF.md
# Accumulator Processor Core with Unified Byte Memory

This block is a small 8-bit processor built around a single accumulator. Program and data share one memory of 32 bytes held inside the block. Every instruction is one byte. The top three bits select the operation and the low five bits give a memory address or a jump target. Each instruction runs as three clock cycles. In the fetch cycle the core reads the instruction and advances the program counter. In the decode cycle it reads the addressed operand. In the execute cycle it updates the accumulator, the memory or the program counter.

The operations are:
- load from memory
- store to memory
- subtract a memory operand
- take a byte from an external input port through a valid/ready handshake
- jump when the accumulator is zero
- jump when the accumulator is positive
- halt
- one reserved code, which acts as a no-op

A separate write port lets the environment fill the memory before a program runs. This is how a program is loaded, for example a greatest-common-divisor routine that works by repeated subtraction.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low and at the first sample after it rises, `pc_out`, `acc_out` and `halted` are all zero, and the first instruction is fetched from address 0.
- R2: The opcode is in bits 7:5 of an instruction and the address or target is in bits 4:0. Each instruction takes exactly three cycles: fetch, then decode, then execute. `pc_out` advances by one (5-bit wrap) at the end of the fetch cycle, so a program whose seventh instruction (address 6) is a halt raises `halted` on the 21st rising edge after reset.
- R3: Opcode 000 loads the accumulator from the addressed location. Opcode 001 writes the accumulator to the addressed location, and a later load from that location returns the written value.
- R4: Opcode 011 replaces the accumulator with the accumulator minus the addressed location's contents, using 8-bit two's-complement wrap-around (7 - 10 gives 0xFD).
- R5: Opcode 100 ignores its address field. It holds the core in the execute cycle, with the accumulator unchanged, while `in_valid` is low. When `in_valid` is high, `in_ready` is high for that one cycle and `in_data` is written into the accumulator.
- R6: Opcode 101 loads the 5-bit target into the PC when the accumulator is zero. Otherwise execution continues at the next address.
- R7: Opcode 110 loads the 5-bit target into the PC when the accumulator is positive, meaning bit 7 is clear and the value is non-zero. Otherwise execution continues; 0x00 and 0x80 do not jump.
- R8: Opcode 111 sets `halted`. From then until reset, `pc_out`, `acc_out` and `halted` hold their values and `in_ready` stays low whatever `in_valid` does.
- R9: Opcode 010 changes neither the accumulator nor memory, and execution continues at the next address.
- R10: When `pre_we` is high at a rising edge, `pre_data` is written to the location `pre_addr`. This write takes priority over a store in the same cycle, and memory contents are not cleared by reset.
- R11: A subtraction-based GCD program that reads two values below 128 through the input port halts with their greatest common divisor in the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the core state |
| pre_we | input | 1 | Memory preload write enable |
| pre_addr | input | 5 | Memory preload address |
| pre_data | input | 8 | Memory preload data |
| in_valid | input | 1 | Input port holds a byte |
| in_data | input | 8 | Input port byte |
| in_ready | output | 1 | Input byte taken this cycle |
| acc_out | output | 8 | Accumulator value |
| pc_out | output | 5 | Program counter value |
| halted | output | 1 | Core has executed a halt |

## Verification
The assertions assume two things about the environment. First, once `in_valid` is raised it stays high, with `in_data` steady, until `in_ready` has been seen. Second, `pre_we` is only used while reset holds the core idle. The bench meets both: it loads every program under reset, and its input driver lowers `in_valid` only on the falling edge after the transfer. It also inserts chosen stall delays before each input byte. The GCD operands are kept below 128, so the positive-jump test in the program sees only true differences in sign.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int OPC_W = 3;

   typedef enum logic [OPC_W-1:0] {
      OP_LOAD  = 3'b000,
      OP_STORE = 3'b001,
      OP_NOP   = 3'b010,
      OP_SUB   = 3'b011,
      OP_IN    = 3'b100,
      OP_JZ    = 3'b101,
      OP_JP    = 3'b110,
      OP_HALT  = 3'b111
   } opcode_e;

   typedef enum logic [1:0] {
      S_FETCH,
      S_DECODE,
      S_EXEC,
      S_HALT
   } cpu_state_e;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr_a,
   output logic [DATA_W-1:0] rdata_a,
   input  logic [ADDR_W-1:0] raddr_b,
   output logic [DATA_W-1:0] rdata_b
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) words[waddr] <= wdata;
   end

   assign rdata_a = words[raddr_a];
   assign rdata_b = words[raddr_b];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] diff,
   output logic              is_zero,
   output logic              is_pos
);
   assign diff    = acc - opnd;
   assign is_zero = (acc == '0);
   assign is_pos  = !acc[DATA_W-1] && !is_zero;
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic [DATA_W-1:0] fetch_data,
   output logic [ADDR_W-1:0] oper_addr,
   input  logic [DATA_W-1:0] oper_data,
   output logic              st_we,
   output logic [ADDR_W-1:0] st_addr,
   output logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] alu_diff,
   input  logic              alu_zero,
   input  logic              alu_pos,
   output logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] opnd,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic [ADDR_W-1:0] pc,
   output logic              halted
);
   cpu_state_e        state_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] acc_q, ir_q, opnd_q;
   logic              halted_q;
   opcode_e           op;
   logic [ADDR_W-1:0] field;

   assign op    = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);
   assign field = ir_q[ADDR_W-1:0];

   assign fetch_addr = pc_q;
   assign oper_addr  = field;
   assign st_we      = (state_q == S_EXEC) && (op == OP_STORE);
   assign st_addr    = field;
   assign st_data    = acc_q;
   assign in_ready   = (state_q == S_EXEC) && (op == OP_IN) && in_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_FETCH;
         pc_q     <= '0;
         acc_q    <= '0;
         ir_q     <= '0;
         opnd_q   <= '0;
         halted_q <= 1'b0;
      end else begin
         case (state_q)
            S_FETCH: begin
               ir_q    <= fetch_data;
               pc_q    <= pc_q + 1'b1;
               state_q <= S_DECODE;
            end
            S_DECODE: begin
               opnd_q  <= oper_data;
               state_q <= S_EXEC;
            end
            S_EXEC: begin
               state_q <= S_FETCH;
               case (op)
                  OP_LOAD: acc_q <= opnd_q;
                  OP_SUB:  acc_q <= alu_diff;
                  OP_IN: begin
                     if (in_valid) acc_q <= in_data;
                     else          state_q <= S_EXEC;
                  end
                  OP_JZ: if (alu_zero) pc_q <= field;
                  OP_JP: if (alu_pos)  pc_q <= field;
                  OP_HALT: begin
                     halted_q <= 1'b1;
                     state_q  <= S_HALT;
                  end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   assign acc    = acc_q;
   assign opnd   = opnd_q;
   assign pc     = pc_q;
   assign halted = halted_q;

   // R2
   fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_FETCH) |=> (state_q == S_DECODE));
   // R2
   decode_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DECODE) |=> (state_q == S_EXEC));
   // R5
   in_stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_EXEC && op == OP_IN && !in_valid) |=> (state_q == S_EXEC && $stable(acc_q)));
   // R5
   in_ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |=> !in_ready);
   // R6
   jz_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_EXEC && op == OP_JZ && acc_q == '0) |=> (pc_q == $past(field)));
   // R8
   halted_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted_q |=> (halted_q && $stable(acc_q) && $stable(pc_q) && !in_ready));
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_we,
   input  logic [ADDR_W-1:0] pre_addr,
   input  logic [DATA_W-1:0] pre_data,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic [DATA_W-1:0] acc_out,
   output logic [ADDR_W-1:0] pc_out,
   output logic              halted
);
   generate
      if (DATA_W != OPC_W + ADDR_W) begin : g_bad_width
         $error("instruction width must equal opcode width plus address width");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("address width must be at least one");
      end
   endgenerate

   logic [ADDR_W-1:0] fetch_addr, oper_addr, st_addr, mem_waddr;
   logic [DATA_W-1:0] fetch_data, oper_data, st_data, mem_wdata;
   logic [DATA_W-1:0] acc, opnd, alu_diff;
   logic              st_we, mem_we, alu_zero, alu_pos;

   // preload wins over a store in the same cycle
   assign mem_we    = pre_we | st_we;
   assign mem_waddr = pre_we ? pre_addr : st_addr;
   assign mem_wdata = pre_we ? pre_data : st_data;

   acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr_a(fetch_addr), .rdata_a(fetch_data),
      .raddr_b(oper_addr), .rdata_b(oper_data)
   );

   acc_cpu_alu #(.DATA_W(DATA_W)) i_alu (
      .acc(acc), .opnd(opnd), .diff(alu_diff), .is_zero(alu_zero), .is_pos(alu_pos)
   );

   acc_cpu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ctrl (
      .clk(clk), .rst_n(rst_n),
      .fetch_addr(fetch_addr), .fetch_data(fetch_data),
      .oper_addr(oper_addr), .oper_data(oper_data),
      .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
      .alu_diff(alu_diff), .alu_zero(alu_zero), .alu_pos(alu_pos),
      .acc(acc), .opnd(opnd),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .pc(pc_out), .halted(halted)
   );

   assign acc_out = acc;
endmodule

// File: tb/test_acc_cpu_core.sv
`timescale 1ns/1ps
module test_acc_cpu_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pre_we = 1'b0;
   logic [4:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic       in_ready;
   logic [7:0] acc_out;
   logic [4:0] pc_out;
   logic       halted;

   int total = 0, fails = 0, cyc = 0, ready_cnt = 0;
   int prog [32];
   int m_mem [32];
   int m_pc = 0, m_acc = 0, m_st = 0, m_ir = 0, m_opnd = 0, m_halt = 0;

   always #2.5 clk = ~clk;

   acc_cpu_core i_acc_cpu_core (
      .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .acc_out(acc_out), .pc_out(pc_out), .halted(halted)
   );

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference, one step per rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_pc = 0; m_acc = 0; m_st = 0; m_ir = 0; m_opnd = 0; m_halt = 0;
      end else begin
         case (m_st)
            0: begin m_ir = m_mem[m_pc]; m_pc = (m_pc + 1) % 32; m_st = 1; end
            1: begin m_opnd = m_mem[m_ir % 32]; m_st = 2; end
            2: begin
               m_st = 0;
               case (m_ir / 32)
                  0: m_acc = m_opnd;
                  1: m_mem[m_ir % 32] = m_acc;
                  3: m_acc = (m_acc - m_opnd) & 255;
                  4: if (in_valid) m_acc = int'(in_data); else m_st = 2;
                  5: if (m_acc == 0) m_pc = m_ir % 32;
                  6: if (m_acc != 0 && m_acc < 128) m_pc = m_ir % 32;
                  7: begin m_halt = 1; m_st = 3; end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
      if (pre_we) m_mem[pre_addr] = int'(pre_data);
   end

   // compare against the reference on every clock
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk("R4 acc_out per cycle", int'(acc_out), m_acc);
         chk("R2 pc_out per cycle", int'(pc_out), m_pc);
         chk("R8 halted per cycle", int'(halted), m_halt);
         chk("R5 in_ready per cycle", int'(in_ready),
             int'(m_st == 2 && m_ir / 32 == 4 && in_valid));
         if (in_ready) ready_cnt++;
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         fails++; total++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   task automatic load_and_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int a = 0; a < 32; a++) begin
         pre_we = 1'b1; pre_addr = 5'(a); pre_data = 8'(prog[a]);
         @(negedge clk);
      end
      pre_we = 1'b0;
      @(negedge clk);
      #1;
      chk("R1 pc_out in reset", int'(pc_out), 0);
      chk("R1 acc_out in reset", int'(acc_out), 0);
      chk("R1 halted in reset", int'(halted), 0);
      @(negedge clk);
      rst_n = 1'b1;
      ready_cnt = 0;
   endtask

   task automatic wait_halt(output int n);
      n = 0;
      while (!halted && n < 5000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic send_in(int d, int delay);
      repeat (delay) @(negedge clk);
      in_data = 8'(d); in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic int gcd(int a, int b);
      while (b != 0) begin
         int t = a % b;
         a = b; b = t;
      end
      return a;
   endfunction

   initial begin
      int n;
      int pa [4] = '{84, 13, 100, 120};
      int pb [4] = '{36, 7, 100, 1};
      int dl [4] = '{0, 3, 1, 6};

      // program A: load, subtract, no-op, store, reload
      for (int a = 0; a < 32; a++) prog[a] = 8'hE0;
      prog[0] = 8'h1E; prog[1] = 8'h7F; prog[2] = 8'h40; prog[3] = 8'h3D;
      prog[4] = 8'h1F; prog[5] = 8'h1D; prog[6] = 8'hE0;
      prog[29] = 0; prog[30] = 7; prog[31] = 10;
      load_and_reset();
      #1;
      chk("R1 pc_out after reset release", int'(pc_out), 0);
      wait_halt(n);
      chk("R2 halt on 21st edge", n, 21);
      chk("R4 R3 R9 R10 acc after store/reload", int'(acc_out), 8'hFD);
      chk("R9 pc after no-op program", int'(pc_out), 7);
      in_data = 8'h55; in_valid = 1'b1;
      repeat (10) @(negedge clk);
      #1;
      chk("R8 acc held after halt", int'(acc_out), 8'hFD);
      chk("R8 pc held after halt", int'(pc_out), 7);
      chk("R8 in_ready pulses after halt", ready_cnt, 0);
      in_valid = 1'b0;

      // program B: jump polarity
      for (int a = 0; a < 32; a++) prog[a] = 8'hE0;
      prog[0] = 8'h1E; prog[1] = 8'hCA; prog[2] = 8'hAA; prog[3] = 8'h1D;
      prog[4] = 8'hCA; prog[5] = 8'hA8; prog[8] = 8'h1F; prog[9] = 8'hCC;
      prog[29] = 0; prog[30] = 8'h80; prog[31] = 5;
      load_and_reset();
      wait_halt(n);
      chk("R7 R6 final pc through jumps", int'(pc_out), 13);
      chk("R7 acc after positive jump", int'(acc_out), 5);

      // program C: GCD by subtraction with handshake input
      for (int a = 0; a < 32; a++) prog[a] = 8'h40;
      prog[0] = 8'h80; prog[1] = 8'h3E; prog[2] = 8'h9F; prog[3] = 8'h3F;
      prog[4] = 8'h1E; prog[5] = 8'h7F; prog[6] = 8'hB0; prog[7] = 8'hCD;
      prog[8] = 8'h1F; prog[9] = 8'h7E; prog[10] = 8'h3F; prog[11] = 8'hC4;
      prog[13] = 8'h3E; prog[14] = 8'hC4; prog[16] = 8'h1E; prog[17] = 8'hE0;
      for (int k = 0; k < 4; k++) begin
         load_and_reset();
         fork
            begin
               send_in(pa[k], dl[k]);
               send_in(pb[k], dl[3 - k]);
            end
            wait_halt(n);
         join
         chk("R11 gcd result", int'(acc_out), gcd(pa[k], pb[k]));
         chk("R11 halted after gcd", int'(halted), 1);
         chk("R5 one ready per input byte", ready_cnt, 2);
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule